// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block sits between a synchronous host and an asynchronous 128K x 8 pseudo-static RAM. The host hands it single read, write or read-modify-write requests on a valid/ready port. The controller turns each request into one chip-enable pulse on the memory pins. Every phase of the pulse is sized in system clocks, rounded up from nanosecond minimums held as parameters. Each access closes with a chip-enable precharge. Read data comes back on a one-cycle response strobe.

The controller also brings the memory up after reset and keeps its cells alive. After reset it keeps the chip deselected for the power-up wait, then runs dummy chip-enable cycles, and only then opens the host port. From then on a scheduler raises a refresh request at a fixed interval. The controller answers it with an auto-refresh pulse on the refresh pin while the chip is deselected, followed by a recovery time. An access already in flight finishes first, and the host port stays closed until the refresh is complete. Only the active-low chip enable toggles; the active-high enable is held high.

States: ST_INIT_WAIT (power-up wait) goes to ST_DUMMY_ACT when its timer expires. ST_DUMMY_ACT goes to ST_DUMMY_PRE, which returns to ST_DUMMY_ACT until the last dummy cycle, then goes to ST_IDLE. From ST_IDLE, a due refresh goes to ST_REF_PULSE; otherwise an accepted request goes to ST_READ, ST_WRITE or ST_RMW_READ. ST_READ and ST_WRITE go to ST_PRECHARGE. ST_RMW_READ goes to ST_RMW_TURN (a one-cycle bus turnaround), then to ST_RMW_WRITE, then to ST_PRECHARGE. ST_PRECHARGE returns to ST_IDLE. ST_REF_PULSE goes to ST_REF_RECOVER, which returns to ST_IDLE. Every timed state leaves when its shared down-timer expires.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, chip enable and the refresh pin are high and the bus driver is off. The host port stays not-ready for at least 100 us (25000 clocks at 4 ns), and at least 8 dummy chip-enable pulses are issued before ready first rises.
- R2: A request with req_op 2'b00 or 2'b11 is a read. The address stays stable while chip enable is low. rsp_valid pulses for one cycle carrying the stored byte, 16 clocks after the accepting edge.
- R3: A request with req_op 2'b01 is a write. It stores req_wdata at req_addr, driving the data bus with the write strobe low while chip enable is low; a later read returns it.
- R4: A request with req_op 2'b10 is a read-modify-write under a single chip-enable pulse. It returns the old byte 16 clocks after acceptance and stores req_wdata. Its low time plus the minimum precharge covers at least 165 ns (low for at least 32 clocks).
- R5: Every chip-enable low pulse lasts at least 60 ns (15 clocks), and chip enable stays high at least 40 ns (10 clocks) between pulses.
- R6: The data bus is driven only while chip enable is low and output enable is high, so it never has two drivers.
- R7: Refresh pulses on the active-low refresh pin occur only with chip enable high and last at least 30 ns (8 clocks). While idle they repeat every floor(8 ms / 512 / clock period) = 3906 clocks, and no gap exceeds that interval plus one access.
- R8: When a refresh comes due during an access, the access completes and ready stays low until the pulse and its recovery are done. Ready is never high while the refresh pin is low or within 30 ns of its release.
- R9: The active-high chip enable output is held high at all times.
- R10: Ready drops on the edge that accepts a request and stays low for the whole access. A write produces no rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_op | input | 2 | 00/11 read, 01 write, 10 read-modify-write |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable, held high |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Read/write pin, low writes |
| mem_rfsh_n | output | 1 | Active-low refresh pin |
| mem_dq_out | output | 8 | Data to the memory |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
All pin outputs are registered from the next state, so a pin change lands on the edge that starts its phase. A read's rsp_valid is due 16 clocks after the accepting edge, and ready is already low one clock after acceptance. While idle, refresh pulses start exactly 3906 clocks apart. The bench drives inputs and samples everything on the falling clock edge, counting falling edges from the accepting edge. Its memory model measures pulse widths, precharge, refresh spacing and bus ownership in falling-edge counts, and it returns valid read data only once 62 ns have elapsed since chip enable fell. A read sampled one clock early therefore captures a junk byte.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [3:0] {
        ST_INIT_WAIT,
        ST_DUMMY_ACT,
        ST_DUMMY_PRE,
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RMW_READ,
        ST_RMW_TURN,
        ST_RMW_WRITE,
        ST_PRECHARGE,
        ST_REF_PULSE,
        ST_REF_RECOVER
    } psram_state_e;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_RMW   = 2'b10;

    function automatic int cycles_up(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = enable && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            cnt <= (!enable || tick) ? '0 : cnt + 1'b1;
            due <= tick || (due && !ack);
        end
    end

    AST_REF_ACK_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> due); // R7
    AST_REF_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!due || ack)); // R7
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_NS          = 4,
    parameter int ADDR_W          = 17,
    parameter int DATA_W          = 8,
    parameter int T_CE_NS         = 60,
    parameter int T_PRE_NS        = 40,
    parameter int T_RC_NS         = 100,
    parameter int T_RMW_NS        = 165,
    parameter int T_CEA_NS        = 60,
    parameter int T_WP_NS         = 40,
    parameter int T_FAP_NS        = 30,
    parameter int T_FP_NS         = 30,
    parameter int T_FC_NS         = 160,
    parameter int T_INIT_NS       = 100000,
    parameter int T_REF_WINDOW_NS = 8000000,
    parameter int REF_COUNT       = 512,
    parameter int DUMMY_CYCLES    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_rfsh_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_CE       = cycles_up(T_CE_NS, CLK_NS);
    localparam int N_PRE      = cycles_up(T_PRE_NS, CLK_NS);
    localparam int N_ACT      = imax(N_CE, cycles_up(T_RC_NS, CLK_NS) - N_PRE);
    localparam int N_RD       = imax(N_ACT, cycles_up(T_CEA_NS, CLK_NS) + 1);
    localparam int N_WR       = imax(N_ACT, cycles_up(T_WP_NS, CLK_NS));
    localparam int N_RMW_ACT  = imax(cycles_up(T_RMW_NS, CLK_NS) - N_PRE,
                                     N_RD + 1 + cycles_up(T_WP_NS, CLK_NS));
    localparam int N_RMW_WR   = N_RMW_ACT - N_RD - 1;
    localparam int N_FAP      = cycles_up(T_FAP_NS, CLK_NS);
    localparam int N_FREC     = imax(cycles_up(T_FP_NS, CLK_NS),
                                     cycles_up(T_FC_NS, CLK_NS) - N_FAP);
    localparam int N_INIT     = cycles_up(T_INIT_NS, CLK_NS);
    localparam int N_REF_INT  = (T_REF_WINDOW_NS / REF_COUNT) / CLK_NS;
    localparam int TMR_W      = $clog2(imax(N_INIT, N_RMW_ACT) + 1);
    localparam int DUMMY_W    = $clog2(DUMMY_CYCLES + 1);
    localparam int LEN_W      = $clog2(imax(N_RMW_ACT, imax(N_FREC, N_PRE)) + 2) + 1;

    localparam logic [TMR_W-1:0] L_INIT   = TMR_W'(N_INIT - 1);
    localparam logic [TMR_W-1:0] L_ACT    = TMR_W'(N_ACT - 1);
    localparam logic [TMR_W-1:0] L_PRE    = TMR_W'(N_PRE - 1);
    localparam logic [TMR_W-1:0] L_RD     = TMR_W'(N_RD - 1);
    localparam logic [TMR_W-1:0] L_WR     = TMR_W'(N_WR - 1);
    localparam logic [TMR_W-1:0] L_RMW_WR = TMR_W'(N_RMW_WR - 1);
    localparam logic [TMR_W-1:0] L_FAP    = TMR_W'(N_FAP - 1);
    localparam logic [TMR_W-1:0] L_FREC   = TMR_W'(N_FREC - 1);

    psram_state_e       state, state_nx;
    logic               tmr_load, tmr_expired;
    logic [TMR_W-1:0]   tmr_val;
    logic               ref_due, ref_ack, accept;
    logic [DUMMY_W-1:0] dummy_cnt;

    psram_timer #(.W(TMR_W), .RST_VAL(L_INIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    psram_refresh_sched #(.INTERVAL(N_REF_INT)) u_refresh (
        .clk(clk), .rst_n(rst_n), .enable(state != ST_INIT_WAIT && state != ST_DUMMY_ACT
                                          && state != ST_DUMMY_PRE),
        .ack(ref_ack), .due(ref_due)
    );

    assign req_ready = (state == ST_IDLE) && !ref_due;
    assign mem_ce2   = 1'b1;

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_ack  = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_INIT_WAIT:
                if (tmr_expired) begin
                    state_nx = ST_DUMMY_ACT; tmr_load = 1'b1; tmr_val = L_ACT;
                end
            ST_DUMMY_ACT:
                if (tmr_expired) begin
                    state_nx = ST_DUMMY_PRE; tmr_load = 1'b1; tmr_val = L_PRE;
                end
            ST_DUMMY_PRE:
                if (tmr_expired) begin
                    if (dummy_cnt == DUMMY_W'(DUMMY_CYCLES)) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_DUMMY_ACT; tmr_load = 1'b1; tmr_val = L_ACT;
                    end
                end
            ST_IDLE:
                if (ref_due) begin
                    state_nx = ST_REF_PULSE; tmr_load = 1'b1; tmr_val = L_FAP;
                    ref_ack  = 1'b1;
                end else if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_op == OP_WRITE) begin
                        state_nx = ST_WRITE; tmr_val = L_WR;
                    end else if (req_op == OP_RMW) begin
                        state_nx = ST_RMW_READ; tmr_val = L_RD;
                    end else begin
                        state_nx = ST_READ; tmr_val = L_RD;
                    end
                end
            ST_READ, ST_WRITE, ST_RMW_WRITE:
                if (tmr_expired) begin
                    state_nx = ST_PRECHARGE; tmr_load = 1'b1; tmr_val = L_PRE;
                end
            ST_RMW_READ:
                if (tmr_expired) begin
                    state_nx = ST_RMW_TURN; tmr_load = 1'b1; tmr_val = '0;
                end
            ST_RMW_TURN:
                if (tmr_expired) begin
                    state_nx = ST_RMW_WRITE; tmr_load = 1'b1; tmr_val = L_RMW_WR;
                end
            ST_PRECHARGE, ST_REF_RECOVER:
                if (tmr_expired) state_nx = ST_IDLE;
            ST_REF_PULSE:
                if (tmr_expired) begin
                    state_nx = ST_REF_RECOVER; tmr_load = 1'b1; tmr_val = L_FREC;
                end
            default: state_nx = ST_INIT_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_INIT_WAIT;
            dummy_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DUMMY_ACT && tmr_expired) dummy_cnt <= dummy_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce1_n  <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_rfsh_n <= 1'b1;
            mem_dq_oe  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            mem_ce1_n  <= !(state_nx inside {ST_DUMMY_ACT, ST_READ, ST_WRITE,
                                             ST_RMW_READ, ST_RMW_TURN, ST_RMW_WRITE});
            mem_oe_n   <= !(state_nx inside {ST_READ, ST_RMW_READ});
            mem_we_n   <= !(state_nx inside {ST_WRITE, ST_RMW_WRITE});
            mem_dq_oe  <= (state_nx inside {ST_WRITE, ST_RMW_WRITE});
            mem_rfsh_n <= (state_nx != ST_REF_PULSE);
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            rsp_valid <= (state inside {ST_READ, ST_RMW_READ}) && tmr_expired;
            if ((state inside {ST_READ, ST_RMW_READ}) && tmr_expired) rsp_rdata <= mem_dq_in;
        end
    end

    // Pulse-length monitors used by the timing assertions below
    logic [LEN_W-1:0] ce_lo_len, ce_hi_len, rf_lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_lo_len <= '0;
            ce_hi_len <= '1;
            rf_lo_len <= '0;
        end else begin
            ce_lo_len <= mem_ce1_n ? '0 : ((ce_lo_len == '1) ? ce_lo_len : ce_lo_len + 1'b1);
            ce_hi_len <= !mem_ce1_n ? '0 : ((ce_hi_len == '1) ? ce_hi_len : ce_hi_len + 1'b1);
            rf_lo_len <= mem_rfsh_n ? '0 : ((rf_lo_len == '1) ? rf_lo_len : rf_lo_len + 1'b1);
        end
    end

    AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce1_n)); // R6
    AST_REFRESH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rfsh_n |-> mem_ce1_n); // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && mem_rfsh_n)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && !$past(mem_ce1_n)) |-> $stable(mem_addr)); // R2
    AST_CE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce1_n) |-> (ce_lo_len >= LEN_W'(N_CE))); // R5
    AST_CE_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce1_n) |-> (ce_hi_len >= LEN_W'(N_PRE))); // R5
    AST_RFSH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rfsh_n) |-> (rf_lo_len >= LEN_W'(N_FAP))); // R7
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(mem_oe_n)); // R2
    AST_CE2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rfsh_n |=> (mem_ce2 || !mem_rfsh_n)); // R9
endmodule

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;
    localparam int B_CE_MIN  = 15;    // 60 ns / 4 ns
    localparam int B_PRE_MIN = 10;    // 40 ns / 4 ns
    localparam int B_RD_CNT  = 16;    // ceil((60 ns + 2 ns) / 4 ns)
    localparam int B_OE_CNT  = 7;     // ceil((25 ns + 2 ns) / 4 ns)
    localparam int B_FAP     = 8;     // ceil(30 ns / 4 ns)
    localparam int B_FP      = 8;     // ceil(30 ns / 4 ns)
    localparam int B_INIT    = 25000; // 100 us / 4 ns
    localparam int B_REF_INT = 3906;  // floor(8 ms / 512 / 4 ns)
    localparam int B_RMW_LO  = 32;    // ceil(165 ns / 4 ns) - 10
    localparam int B_RD_LAT  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_rfsh_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    psram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_rfsh_n(mem_rfsh_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural memory and pin-protocol monitor, sampled on falling edges
    logic [7:0]  model_mem [int];
    logic [16:0] lat_addr = '0;
    logic        prev_ce = 1'b1, prev_we = 1'b1, prev_rf = 1'b1, pend = 1'b0;
    logic [7:0]  pend_d = '0;
    int ce_lo = 0, ce_hi = 1000, oe_lo = 0, rf_lo = 0, rf_since = 1000;
    int last_ce_lo = 0, ce_falls = 0, rf_falls = 0, cyc = 0;
    int last_rf = 0, last_gap = 0, max_gap = 0;
    int v_pre = 0, v_ce = 0, v_addr = 0, v_bus = 0, v_rfce = 0, v_rfw = 0, v_rdy = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_ce1_n) begin
                if (prev_ce) begin
                    lat_addr = mem_addr; ce_falls++;
                    if (ce_hi < B_PRE_MIN) v_pre++;
                    ce_lo = 0;
                end else if (mem_addr != lat_addr) v_addr++;
                ce_lo++;
            end else begin
                if (!prev_ce) begin
                    last_ce_lo = ce_lo;
                    if (ce_lo < B_CE_MIN) v_ce++;
                    ce_hi = 0;
                end
                ce_hi++;
            end
            if (!mem_oe_n) oe_lo++; else oe_lo = 0;
            if (!mem_ce1_n && !mem_we_n && mem_dq_oe) begin
                pend = 1'b1; pend_d = mem_dq_out;
            end
            if (pend && ((!prev_we && mem_we_n) || (!prev_ce && mem_ce1_n))) begin
                model_mem[int'(lat_addr)] = pend_d; pend = 1'b0;
            end
            if (mem_dq_oe && (!mem_oe_n || mem_ce1_n)) v_bus++;
            if (!mem_ce1_n && !mem_oe_n && ce_lo >= B_RD_CNT && oe_lo >= B_OE_CNT)
                mem_dq_in = model_mem.exists(int'(lat_addr)) ? model_mem[int'(lat_addr)] : 8'h00;
            else
                mem_dq_in = 8'hEE;
            if (!mem_rfsh_n) begin
                if (!mem_ce1_n) v_rfce++;
                if (prev_rf) begin
                    rf_falls++;
                    if (rf_falls > 1) begin
                        last_gap = cyc - last_rf;
                        if (last_gap > max_gap) max_gap = last_gap;
                    end
                    last_rf = cyc; rf_lo = 0;
                end
                rf_lo++;
                rf_since = 0;
            end else begin
                if (!prev_rf && rf_lo < B_FAP) v_rfw++;
                rf_since = prev_rf ? rf_since + 1 : 1;
            end
            if (req_ready && (!mem_rfsh_n || rf_since < B_FP)) v_rdy++;
            prev_ce = mem_ce1_n; prev_we = mem_we_n; prev_rf = mem_rfsh_n;
        end
    end

    task automatic do_op(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat, output bit got,
                         output bit busy);
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        got = 1'b0; lat = 0; rd = 8'h00;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (rsp_valid && !got) begin
                got = 1'b1; lat = i; rd = rsp_rdata;
            end
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(mem_ce1_n == 1'b1, "R1", "ce1_n in reset", int'(mem_ce1_n), 1);
        check(mem_rfsh_n == 1'b1, "R1", "rfsh_n in reset", int'(mem_rfsh_n), 1);
        check(mem_dq_oe == 1'b0, "R1", "dq_oe in reset", int'(mem_dq_oe), 0);
        check(req_ready == 1'b0, "R1", "ready in reset", int'(req_ready), 0);
        check(mem_ce2 == 1'b1, "R9", "ce2 in reset", int'(mem_ce2), 1);
    endtask

    task automatic t_init();
        int n = 0;
        while (!req_ready && n < 40000) begin
            @(negedge clk); n++;
        end
        check(n >= B_INIT, "R1", "clocks before first ready", n, B_INIT);
        check(ce_falls >= 8, "R1", "dummy cycles before ready", ce_falls, 8);
    endtask

    task automatic t_write_read();
        logic [16:0] addrs [5] = '{17'h00000, 17'h1FFFF, 17'h0A5A5, 17'h15A5A, 17'h00100};
        logic [7:0]  datas [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C};
        logic [7:0] rd; int lat; bit got, busy;
        foreach (addrs[i]) begin
            do_op(2'b01, addrs[i], datas[i], rd, lat, got, busy);
            check(!got, "R10", "write gave a response", int'(got), 0);
            check(busy, "R10", "ready low after accept", int'(!busy), 0);
        end
        foreach (addrs[i]) begin
            do_op((i % 2 == 0) ? 2'b00 : 2'b11, addrs[i], 8'h00, rd, lat, got, busy);
            check(got && rd == datas[i], "R3", "read-back data", int'(rd), int'(datas[i]));
            check(lat == B_RD_LAT, "R2", "read response latency", lat, B_RD_LAT);
        end
    endtask

    task automatic t_rmw();
        logic [7:0] rd; int lat; bit got, busy;
        int falls0;
        falls0 = ce_falls;
        do_op(2'b10, 17'h0A5A5, 8'h77, rd, lat, got, busy);
        check(got && rd == 8'hFF, "R4", "rmw old data", int'(rd), 255);
        check(lat == B_RD_LAT, "R4", "rmw response latency", lat, B_RD_LAT);
        check(ce_falls - falls0 == 1, "R4", "rmw chip-enable pulses", ce_falls - falls0, 1);
        check(last_ce_lo >= B_RMW_LO, "R4", "rmw low clocks", last_ce_lo, B_RMW_LO);
        do_op(2'b00, 17'h0A5A5, 8'h00, rd, lat, got, busy);
        check(rd == 8'h77, "R4", "rmw new data stored", int'(rd), 119);
    endtask

    task automatic t_refresh_idle();
        int f0;
        repeat (200) @(negedge clk);
        f0 = rf_falls;
        repeat (4 * B_REF_INT) @(negedge clk);
        check(rf_falls - f0 == 4, "R7", "idle refresh pulses in 4 intervals", rf_falls - f0, 4);
        check(last_gap == B_REF_INT, "R7", "idle refresh spacing", last_gap, B_REF_INT);
    endtask

    task automatic t_traffic_refresh();
        logic [7:0] rd; int lat; bit got, busy;
        int f0, bad;
        f0 = rf_falls; bad = 0;
        for (int i = 0; i < 70; i++) begin
            do_op(2'b01, 17'h00200 + 17'(i), 8'(i * 37 + 5), rd, lat, got, busy);
            do_op(2'b00, 17'h00200 + 17'(i), 8'h00, rd, lat, got, busy);
            if (rd != 8'(i * 37 + 5)) bad++;
        end
        check(bad == 0, "R8", "data errors under refresh traffic", bad, 0);
        check(rf_falls - f0 >= 2, "R8", "refreshes during traffic", rf_falls - f0, 2);
        check(max_gap <= B_REF_INT + 48, "R7", "largest refresh gap", max_gap, B_REF_INT + 48);
    endtask

    task automatic t_monitors();
        check(v_bus == 0, "R6", "bus driven with output enable low", v_bus, 0);
        check(v_ce == 0, "R5", "short chip-enable pulses", v_ce, 0);
        check(v_pre == 0, "R5", "short precharges", v_pre, 0);
        check(v_addr == 0, "R2", "address changes under chip enable", v_addr, 0);
        check(v_rfce == 0, "R7", "refresh with chip enable low", v_rfce, 0);
        check(v_rfw == 0, "R7", "short refresh pulses", v_rfw, 0);
        check(v_rdy == 0, "R8", "ready during refresh", v_rdy, 0);
        check(mem_ce2 == 1'b1, "R9", "ce2 at end", int'(mem_ce2), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1 run incomplete actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        t_init();
        t_write_read();
        t_rmw();
        t_refresh_idle();
        t_traffic_refresh();
        t_monitors();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule